// File: doc/BRIEF.md
# Hysteretic Protection Fault Monitor

This block watches one measured quantity (a cell voltage, a pack voltage, a temperature or a signed current) and raises a fault flag when it crosses a programmable trip limit. A second, programmable release limit sets the hysteresis band. The flag drops only after the quantity has stayed inside the release region for a programmed number of seconds.

A one-second tick input paces both the optional trip delay and the release delay. Each new fault adds one to an occurrence counter. The counter saturates at its maximum and can be cleared by a command input.

Two parameters fix the variant of an instance:
- Over-limit or under-limit polarity.
- Signed or unsigned comparison.

One instance drives one bit of a chip-level fault status word. In the usual mapping, cell over, cell under, pack over and pack under take bits 0 to 3, and charge and discharge overcurrent take bits 8 and 9. The unit above the block supplies the measurements and acts on the flag.

Top module: `hyst_fault_mon`

## Requirements
- R1: While `rst_n` is low, `fault` is 0 and `fault_cnt` is 0.
- R2: With `trip_dly` = 0, `fault` rises on the first clock edge at which the sample is strictly beyond `trip_thr`. A sample equal to `trip_thr` never trips.
- R3: With `trip_dly` = N > 0, the trip condition must hold without a break. `fault` then rises on the edge that samples the Nth `tick_1s` pulse counted after the condition began. If the condition lapses before that, the count is discarded and starts again from zero.
- R4: While `fault` is set and the sample has not passed `rel_thr` into the release region, `fault` stays 1, whatever ticks arrive. Release-region passing is strict.
- R5: With `rel_dly` = N > 0, `fault` falls on the edge that samples the Nth tick counted after the sample entered the release region. With `rel_dly` = 0, `fault` falls on the first edge at which the sample is in the release region.
- R6: If the sample leaves the release region before the release delay expires, the release count restarts from zero.
- R7: `fault_cnt` increments by exactly one on each clock edge at which `fault` goes from 0 to 1, and at no other edge.
- R8: `fault_cnt` saturates at 2^CNT_W−1. Further faults leave it there.
- R9: `cnt_clr` high at an edge sets `fault_cnt` to 0 at that edge. This takes priority over an increment on the same edge and does not change `fault`.
- R10: With `OVER_LIMIT` = 0, tripping happens below `trip_thr` and release above `rel_thr`. With `SIGNED_CMP` = 1, the sample and both thresholds are read as two's-complement. For example, with a trip level of −500, a sample of +100 does not trip and −501 does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1s | input | 1 | One-cycle pulse per second, paces both delays |
| cnt_clr | input | 1 | Clears the occurrence counter |
| sample | input | VAL_W | Measured quantity |
| trip_thr | input | VAL_W | Trip threshold |
| rel_thr | input | VAL_W | Release threshold |
| trip_dly | input | DLY_W | Trip delay in ticks (0 = immediate) |
| rel_dly | input | DLY_W | Release delay in ticks (0 = immediate) |
| fault | output | 1 | Fault flag |
| fault_cnt | output | CNT_W | Saturating fault occurrence counter |

## Verification
Every result is registered once. A new sample, a tick or a clear changes `fault` and `fault_cnt` on the next clock edge, one cycle after the stimulus. A delay expires on the edge that samples its final tick. A sample change that moves the sequencer into a timing state costs one edge before ticks start to count, so the bench always spends that cycle before pulsing the tick. The driver records each expected value together with the cycle index at which it is due. The monitor compares only in that cycle, a quarter period after the edge. As a result, a result one cycle early or late shows up as a mismatch rather than passing by chance.

// File: rtl/hfm_pkg.sv
package hfm_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR     = 2'd0,
        ST_ARMING    = 2'd1,
        ST_ACTIVE    = 2'd2,
        ST_RELEASING = 2'd3
    } hfm_state_e;

    function automatic logic is_faulted(input hfm_state_e s);
        return (s == ST_ACTIVE) || (s == ST_RELEASING);
    endfunction

endpackage

// File: rtl/hfm_compare.sv
module hfm_compare #(
    parameter int VAL_W      = 16,
    parameter bit OVER_LIMIT = 1'b1,
    parameter bit SIGNED_CMP = 1'b0
) (
    input  logic [VAL_W-1:0] sample,
    input  logic [VAL_W-1:0] trip_thr,
    input  logic [VAL_W-1:0] rel_thr,
    output logic             trip_cond,
    output logic             rel_cond
);
    logic above_trip, below_trip, above_rel, below_rel;

    generate
        if (SIGNED_CMP) begin : g_signed
            always_comb begin
                above_trip = $signed(sample) > $signed(trip_thr);
                below_trip = $signed(sample) < $signed(trip_thr);
                above_rel  = $signed(sample) > $signed(rel_thr);
                below_rel  = $signed(sample) < $signed(rel_thr);
            end
        end else begin : g_unsigned
            always_comb begin
                above_trip = sample > trip_thr;
                below_trip = sample < trip_thr;
                above_rel  = sample > rel_thr;
                below_rel  = sample < rel_thr;
            end
        end
    endgenerate

    generate
        if (OVER_LIMIT) begin : g_over
            assign trip_cond = above_trip;
            assign rel_cond  = below_rel;
        end else begin : g_under
            assign trip_cond = below_trip;
            assign rel_cond  = above_rel;
        end
    endgenerate

endmodule

// File: rtl/hfm_seq.sv
module hfm_seq
    import hfm_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_1s,
    input  logic             trip_cond,
    input  logic             rel_cond,
    input  logic [DLY_W-1:0] trip_dly,
    input  logic [DLY_W-1:0] rel_dly,
    output logic             fault,
    output logic             rise
);
    localparam int TW = DLY_W + 1;

    typedef struct packed {
        hfm_state_e       st;
        logic [DLY_W-1:0] tmr;
    } seq_t;

    seq_t    cur_q, nxt_d;
    logic [TW-1:0] tmr_inc;

    always_comb begin
        nxt_d   = cur_q;
        tmr_inc = {1'b0, cur_q.tmr} + TW'(1);
        unique case (cur_q.st)
            ST_CLEAR: begin
                if (trip_cond) begin
                    nxt_d.tmr = '0;
                    nxt_d.st  = (trip_dly == '0) ? ST_ACTIVE : ST_ARMING;
                end
            end
            ST_ARMING: begin
                if (!trip_cond) begin
                    nxt_d.st  = ST_CLEAR;
                    nxt_d.tmr = '0;
                end else if (tick_1s) begin
                    if (tmr_inc >= {1'b0, trip_dly}) begin
                        nxt_d.st  = ST_ACTIVE;
                        nxt_d.tmr = '0;
                    end else begin
                        nxt_d.tmr = tmr_inc[DLY_W-1:0];
                    end
                end
            end
            ST_ACTIVE: begin
                if (rel_cond) begin
                    nxt_d.tmr = '0;
                    nxt_d.st  = (rel_dly == '0) ? ST_CLEAR : ST_RELEASING;
                end
            end
            ST_RELEASING: begin
                if (!rel_cond) begin
                    nxt_d.st  = ST_ACTIVE;
                    nxt_d.tmr = '0;
                end else if (tick_1s) begin
                    if (tmr_inc >= {1'b0, rel_dly}) begin
                        nxt_d.st  = ST_CLEAR;
                        nxt_d.tmr = '0;
                    end else begin
                        nxt_d.tmr = tmr_inc[DLY_W-1:0];
                    end
                end
            end
            default: nxt_d = '{st: ST_CLEAR, tmr: '0};
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_CLEAR, tmr: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign fault = is_faulted(cur_q.st);
    assign rise  = is_faulted(nxt_d.st) && !is_faulted(cur_q.st);

endmodule

// File: rtl/hfm_counter.sv
module hfm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/hyst_fault_mon.sv
module hyst_fault_mon #(
    parameter int VAL_W      = 16,
    parameter int DLY_W      = 8,
    parameter int CNT_W      = 16,
    parameter bit OVER_LIMIT = 1'b1,
    parameter bit SIGNED_CMP = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_1s,
    input  logic             cnt_clr,
    input  logic [VAL_W-1:0] sample,
    input  logic [VAL_W-1:0] trip_thr,
    input  logic [VAL_W-1:0] rel_thr,
    input  logic [DLY_W-1:0] trip_dly,
    input  logic [DLY_W-1:0] rel_dly,
    output logic             fault,
    output logic [CNT_W-1:0] fault_cnt
);
    logic trip_cond, rel_cond, rise;

    hfm_compare #(
        .VAL_W      (VAL_W),
        .OVER_LIMIT (OVER_LIMIT),
        .SIGNED_CMP (SIGNED_CMP)
    ) u_cmp (
        .sample    (sample),
        .trip_thr  (trip_thr),
        .rel_thr   (rel_thr),
        .trip_cond (trip_cond),
        .rel_cond  (rel_cond)
    );

    hfm_seq #(
        .DLY_W (DLY_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_1s   (tick_1s),
        .trip_cond (trip_cond),
        .rel_cond  (rel_cond),
        .trip_dly  (trip_dly),
        .rel_dly   (rel_dly),
        .fault     (fault),
        .rise      (rise)
    );

    hfm_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (rise),
        .clr   (cnt_clr),
        .cnt   (fault_cnt)
    );

endmodule

// File: rtl/hfm_checker.sv
module hfm_checker #(
    parameter int DLY_W = 8,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_clr,
    input logic             trip_cond,
    input logic             rel_cond,
    input logic [DLY_W-1:0] trip_dly,
    input logic             fault,
    input logic [CNT_W-1:0] fault_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // R2: immediate trip when no trip delay is programmed
    p_trip_now_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault && trip_cond && trip_dly == '0) |=> fault);

    // R3: no fault can appear while the trip condition is absent
    p_no_false_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault && !trip_cond) |=> !fault);

    // R4: flag holds outside the release region
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !rel_cond) |=> fault);

    // R7: a rising fault adds exactly one
    p_rise_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault && !cnt_clr && fault_cnt != CNT_MAX) ##1 fault
        |-> fault_cnt == $past(fault_cnt) + CNT_W'(1));

    // R7: no count change while the flag is already set
    p_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !cnt_clr) |=> $stable(fault_cnt));

    // R8: saturation
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_cnt == CNT_MAX && !cnt_clr) |=> fault_cnt == CNT_MAX);

    // R9: clear wins
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> fault_cnt == '0);

endmodule

bind hyst_fault_mon hfm_checker #(
    .DLY_W (DLY_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_clr   (cnt_clr),
    .trip_cond (trip_cond),
    .rel_cond  (rel_cond),
    .trip_dly  (trip_dly),
    .fault     (fault),
    .fault_cnt (fault_cnt)
);

// File: tb/hyst_fault_mon_test.sv
module hyst_fault_mon_test;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic clr = 1'b0;

    logic [15:0] s1 = 16'd0, t1 = 16'd1000, r1 = 16'd900;
    logic [7:0]  td1 = 8'd0, rd1 = 8'd2;
    logic        f1;
    logic [15:0] c1;

    logic [15:0] s2 = 16'd0, t2 = 16'hFE0C, r2 = 16'hFE70;
    logic [7:0]  td2 = 8'd0, rd2 = 8'd1;
    logic        f2;
    logic [15:0] c2;

    logic [15:0] s3 = 16'd0, t3 = 16'd10, r3v = 16'd5;
    logic [7:0]  td3 = 8'd0, rd3 = 8'd0;
    logic        f3;
    logic [3:0]  c3;

    hyst_fault_mon uut (
        .clk(clk), .rst_n(rst_n), .tick_1s(tick), .cnt_clr(clr),
        .sample(s1), .trip_thr(t1), .rel_thr(r1),
        .trip_dly(td1), .rel_dly(rd1), .fault(f1), .fault_cnt(c1));

    hyst_fault_mon #(.OVER_LIMIT(1'b0), .SIGNED_CMP(1'b1)) uut_dsg (
        .clk(clk), .rst_n(rst_n), .tick_1s(tick), .cnt_clr(clr),
        .sample(s2), .trip_thr(t2), .rel_thr(r2),
        .trip_dly(td2), .rel_dly(rd2), .fault(f2), .fault_cnt(c2));

    hyst_fault_mon #(.CNT_W(4)) uut_sat (
        .clk(clk), .rst_n(rst_n), .tick_1s(tick), .cnt_clr(clr),
        .sample(s3), .trip_thr(t3), .rel_thr(r3v),
        .trip_dly(td3), .rel_dly(rd3), .fault(f3), .fault_cnt(c3));

    typedef struct {
        int          due;
        int          sel;
        logic [15:0] val;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] observe(int sel);
        case (sel)
            0: return {15'd0, f1};
            1: return c1;
            2: return {15'd0, f2};
            3: return c2;
            4: return {12'd0, c3};
            default: return {15'd0, f3};
        endcase
    endfunction

    // driver side: record an expected value due lat edges from now
    task automatic expect_at(int lat, int sel, logic [15:0] val, string tag);
        exp_t e;
        e.due = cyc + lat;
        e.sel = sel;
        e.val = val;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick();
        step(1);
        tick = 1'b1;
        step(1);
        tick = 1'b0;
    endtask

    // monitor: compare due items a quarter period after each edge
    always @(posedge clk) begin
        #5;
        for (int i = exp_q.size() - 1; i >= 0; i--) begin
            if (exp_q[i].due == cyc) begin
                logic [15:0] act;
                act = observe(exp_q[i].sel);
                n_cmp++;
                if (act !== exp_q[i].val) begin
                    n_bad++;
                    $display("FAIL %s sel=%0d cyc=%0d actual=%0h expected=%0h",
                             exp_q[i].tag, exp_q[i].sel, cyc, act, exp_q[i].val);
                end
                exp_q.delete(i);
            end
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(2);
        expect_at(1, 0, 16'd0, "R1");
        expect_at(1, 1, 16'd0, "R1");
        expect_at(1, 2, 16'd0, "R1");
        expect_at(1, 4, 16'd0, "R1");
        step(2);
        rst_n = 1'b1;

        // R2: equal does not trip, strictly above trips at once
        step(1);
        s1 = 16'd1000;
        expect_at(1, 0, 16'd0, "R2");
        expect_at(3, 0, 16'd0, "R2");
        step(4);
        s1 = 16'd1001;
        expect_at(1, 0, 16'd1, "R2");
        expect_at(1, 1, 16'd1, "R7");

        // R4: inside the band, ticks do not release
        step(1);
        s1 = 16'd950;
        pulse_tick();
        pulse_tick();
        pulse_tick();
        expect_at(1, 0, 16'd1, "R4");
        expect_at(1, 1, 16'd1, "R7");

        // R6: leaving release region restarts the count
        step(1);
        s1 = 16'd899;
        step(1);
        tick = 1'b1;
        expect_at(1, 0, 16'd1, "R6");
        step(1);
        tick = 1'b0;
        s1 = 16'd950;
        step(1);
        s1 = 16'd899;
        step(1);
        tick = 1'b1;
        expect_at(1, 0, 16'd1, "R6");
        step(1);
        tick = 1'b0;
        // R5: second tick after re-entry expires delay of 2
        step(1);
        tick = 1'b1;
        expect_at(1, 0, 16'd0, "R5");
        step(1);
        tick = 1'b0;

        // R5: zero release delay clears on the next edge
        rd1 = 8'd0;
        s1 = 16'd1200;
        expect_at(1, 0, 16'd1, "R2");
        expect_at(1, 1, 16'd2, "R7");
        step(1);
        s1 = 16'd800;
        expect_at(1, 0, 16'd0, "R5");

        // R3: trip delay of 3 with a lapse in between
        step(1);
        td1 = 8'd3;
        s1 = 16'd1200;
        step(1);
        pulse_tick();
        pulse_tick();
        expect_at(1, 0, 16'd0, "R3");
        step(1);
        s1 = 16'd950;
        step(1);
        s1 = 16'd1200;
        step(1);
        pulse_tick();
        pulse_tick();
        expect_at(1, 0, 16'd0, "R3");
        step(1);
        tick = 1'b1;
        expect_at(1, 0, 16'd1, "R3");
        expect_at(1, 1, 16'd3, "R7");
        step(1);
        tick = 1'b0;

        // R9: clear keeps the flag, and wins over a same-edge rise
        step(1);
        clr = 1'b1;
        expect_at(1, 1, 16'd0, "R9");
        expect_at(1, 0, 16'd1, "R9");
        step(1);
        clr = 1'b0;
        td1 = 8'd0;
        s1 = 16'd500;
        expect_at(1, 0, 16'd0, "R5");
        step(1);
        s1 = 16'd1200;
        clr = 1'b1;
        expect_at(1, 0, 16'd1, "R9");
        expect_at(1, 1, 16'd0, "R9");
        step(1);
        clr = 1'b0;
        expect_at(2, 1, 16'd0, "R7");
        step(3);

        // R10: signed under-limit instance
        s2 = 16'd100;
        expect_at(1, 2, 16'd0, "R10");
        step(2);
        s2 = 16'hFE0B;
        expect_at(1, 2, 16'd1, "R10");
        expect_at(1, 3, 16'd1, "R10");
        step(1);
        s2 = 16'hFE3E;
        pulse_tick();
        expect_at(1, 2, 16'd1, "R10");
        step(1);
        s2 = 16'hFE71;
        step(1);
        tick = 1'b1;
        expect_at(1, 2, 16'd0, "R10");
        step(1);
        tick = 1'b0;

        // R8: four-bit counter saturates at 15
        for (int k = 1; k <= 17; k++) begin
            step(1);
            s3 = 16'd20;
            step(1);
            s3 = 16'd0;
            if (k == 15 || k == 17) expect_at(1, 4, 16'd15, "R8");
            if (k == 14) expect_at(1, 4, 16'd14, "R7");
        end

        step(4);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule